// File: doc/BRIEF.md
# Dual-Port Address-Match Busy Arbiter

This block sits in front of a memory array shared by two ports, called left and right. Each port presents an enable, an address and a write request. When both ports are enabled on the same address, the block decides which one holds that location. It drives an active-low busy flag to the port that lost. It also produces a per-port write permit, so a write from the losing port never reaches the array. Reads are never stopped; the busy flag only tells the losing port that its data may be stale.

A mode input picks between two behaviours. In master mode the block arbitrates and drives both busy outputs. In slave mode it does no arbitration: its busy outputs rest high, and two busy inputs, normally fed from a master's outputs, do nothing but block writes. This lets several arrays that share an address range follow one arbiter. All outputs are registered. Every output reflects the inputs sampled at the preceding rising clock edge.

Top module: `dual_port_busy_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, both busy outputs are high and both write permits are low.
- R2: If either port is disabled, or the two addresses differ, both busy outputs are high one cycle later.
- R3: The busy outcome depends only on enables and addresses; write requests of either port do not change which port is flagged busy.
- R4: When a port newly matches the address of a port that was already enabled on that address in the previous cycle, the newcomer's busy output goes low one cycle later and the other port's stays high.
- R5: When both ports begin matching in the same cycle, the right busy output goes low and the left stays high.
- R6: The two busy outputs are never low at the same time.
- R7: In master mode a port's write permit is high one cycle after a cycle in which that port is enabled, requests a write and is not the port flagged busy; otherwise it is low.
- R8: Busy is released (goes high) one cycle after the addresses stop matching or either enable drops.
- R9: While the match persists, the port flagged busy stays the same, whatever the write requests do.
- R10: In slave mode both busy outputs stay high, and a port's write permit is its enable AND its write request AND its busy input (low blocks the write), one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | 1 = arbitrate and drive busy, 0 = busy inputs only inhibit writes |
| l_en | input | 1 | Left port enable, active high |
| l_addr | input | ADDR_W | Left port address |
| l_wr | input | 1 | Left port write request |
| r_en | input | 1 | Right port enable, active high |
| r_addr | input | ADDR_W | Right port address |
| r_wr | input | 1 | Right port write request |
| l_busy_in_n | input | 1 | Left write inhibit in slave mode, active low |
| r_busy_in_n | input | 1 | Right write inhibit in slave mode, active low |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_busy_n | output | 1 | Right busy flag, active low |
| l_wr_ok | output | 1 | Left write permit to the array |
| r_wr_ok | output | 1 | Right write permit to the array |

## Verification
The bench goes after arrival order in both directions. It covers the left port settling first and the right moving onto its address, and then the reverse. A design that picked the winner by a fixed priority would flag the wrong side in one of the two. It then starts a collision in one cycle from a deselected state, which pins the right-side tie-break; a design that flagged both or neither would break R5 or R6. It also changes write requests in the middle of a held collision, which catches a design that re-arbitrates or lets the loser write. Last, it drops one enable while the addresses still match and drives slave mode with busy inputs of both polarities, which exposes releases that wait for an address change and slave outputs that still arbitrate.

// File: rtl/dpba_pkg.sv
package dpba_pkg;
  typedef enum logic [1:0] {
    LK_NONE       = 2'd0,
    LK_LEFT_LOSES = 2'd1,
    LK_RIGHT_LOSES = 2'd2
  } lock_e;

  localparam int SIDES = 2;
  localparam int SIDE_L = 0;
  localparam int SIDE_R = 1;
endpackage

// File: rtl/dpba_port_track.sv
module dpba_port_track #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              settled
);
  logic              prev_en;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_en   <= 1'b0;
      prev_addr <= '0;
    end else begin
      prev_en   <= en;
      prev_addr <= addr;
    end
  end

  // Port held the same enabled address in the previous cycle.
  assign settled = en & prev_en & (prev_addr == addr);
endmodule

// File: rtl/dpba_lock_fsm.sv
module dpba_lock_fsm
  import dpba_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  arb_on,
  input  logic  match,
  input  logic  l_settled,
  input  logic  r_settled,
  output lock_e lock_next,
  output lock_e lock_q
);
  always_comb begin
    lock_next = LK_NONE;
    if (arb_on && match) begin
      if (lock_q != LK_NONE)
        lock_next = lock_q;
      else if (r_settled && !l_settled)
        lock_next = LK_LEFT_LOSES;
      else
        lock_next = LK_RIGHT_LOSES;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lock_q <= LK_NONE;
    else     lock_q <= lock_next;
  end

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (arb_on && match && lock_q != LK_NONE) |=> (lock_q == $past(lock_q))); // R9
  AST_FIRST_WINS: assert property (@(posedge clk) disable iff (rst)
    (arb_on && match && lock_q == LK_NONE && l_settled && !r_settled)
      |=> (lock_q == LK_RIGHT_LOSES)); // R4
endmodule

// File: rtl/dual_port_busy_arbiter.sv
module dual_port_busy_arbiter
  import dpba_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              l_wr_ok,
  output logic              r_wr_ok
);
  logic [SIDES-1:0]             en_v;
  logic [SIDES-1:0]             wr_v;
  logic [SIDES-1:0]             ext_ok_v;
  logic [SIDES-1:0][ADDR_W-1:0] addr_v;
  logic [SIDES-1:0]             settled_v;
  logic [SIDES-1:0]             loses_next;
  logic [SIDES-1:0]             wr_ok_q;
  logic                         match;
  lock_e                        lock_next;
  lock_e                        lock_q;

  assign en_v     = {r_en, l_en};
  assign wr_v     = {r_wr, l_wr};
  assign ext_ok_v = {r_busy_in_n, l_busy_in_n};
  assign addr_v   = {r_addr, l_addr};

  assign match = l_en & r_en & (l_addr == r_addr);

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    dpba_port_track #(.ADDR_W(ADDR_W)) u_track (
      .clk     (clk),
      .rst     (rst),
      .en      (en_v[s]),
      .addr    (addr_v[s]),
      .settled (settled_v[s])
    );
  end

  dpba_lock_fsm u_lock (
    .clk       (clk),
    .rst       (rst),
    .arb_on    (master_mode),
    .match     (match),
    .l_settled (settled_v[SIDE_L]),
    .r_settled (settled_v[SIDE_R]),
    .lock_next (lock_next),
    .lock_q    (lock_q)
  );

  assign loses_next[SIDE_L] = (lock_next == LK_LEFT_LOSES);
  assign loses_next[SIDE_R] = (lock_next == LK_RIGHT_LOSES);

  for (genvar s = 0; s < SIDES; s++) begin : g_permit
    always_ff @(posedge clk) begin
      if (rst)              wr_ok_q[s] <= 1'b0;
      else if (master_mode) wr_ok_q[s] <= en_v[s] & wr_v[s] & ~loses_next[s];
      else                  wr_ok_q[s] <= en_v[s] & wr_v[s] & ext_ok_v[s];
    end
  end

  assign l_busy_n = (lock_q != LK_LEFT_LOSES);
  assign r_busy_n = (lock_q != LK_RIGHT_LOSES);
  assign l_wr_ok  = wr_ok_q[SIDE_L];
  assign r_wr_ok  = wr_ok_q[SIDE_R];

  AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (rst)
    (l_busy_n || r_busy_n)); // R6
  AST_RELEASE_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
    !match |=> (l_busy_n && r_busy_n)); // R8
  AST_LEFT_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    !l_busy_n |-> !l_wr_ok); // R7
  AST_RIGHT_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    !r_busy_n |-> !r_wr_ok); // R7
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !master_mode |=> (l_busy_n && r_busy_n)); // R10
  AST_SLAVE_INHIBIT: assert property (@(posedge clk) disable iff (rst)
    (!master_mode && !l_busy_in_n) |=> !l_wr_ok); // R10
  AST_TIE_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (master_mode && match && lock_q == LK_NONE && !settled_v[SIDE_L] && !settled_v[SIDE_R])
      |=> (!r_busy_n && l_busy_n)); // R5
endmodule

// File: tb/dual_port_busy_arbiter_test.sv
module dual_port_busy_arbiter_test;
  localparam int AW = 16;

  typedef struct {
    logic  lb;
    logic  rb;
    logic  lok;
    logic  rok;
    string req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          master_mode = 1'b1;
  logic          l_en = 1'b0, r_en = 1'b0, l_wr = 1'b0, r_wr = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic          l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
  logic          l_busy_n, r_busy_n, l_wr_ok, r_wr_ok;

  int   checks = 0;
  int   errors = 0;
  exp_t q[$];
  bit   done = 1'b0;

  always #5 clk = ~clk;

  dual_port_busy_arbiter #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .master_mode(master_mode),
    .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr),
    .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
  );

  task automatic step(input logic mm, input logic le, input logic [AW-1:0] la, input logic lw,
                      input logic re, input logic [AW-1:0] ra, input logic rw,
                      input logic lbi, input logic rbi,
                      input logic xlb, input logic xrb, input logic xlok, input logic xrok,
                      input string req);
    exp_t e;
    @(negedge clk);
    master_mode = mm; l_en = le; l_addr = la; l_wr = lw;
    r_en = re; r_addr = ra; r_wr = rw; l_busy_in_n = lbi; r_busy_in_n = rbi;
    e.lb = xlb; e.rb = xrb; e.lok = xlok; e.rok = xrok; e.req = req;
    q.push_back(e);
  endtask

  task automatic cmp(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Monitor: each rising edge consumes the item pushed before it.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.req, "l_busy_n", l_busy_n, e.lb);
        cmp(e.req, "r_busy_n", r_busy_n, e.rb);
        cmp(e.req, "l_wr_ok", l_wr_ok, e.lok);
        cmp(e.req, "r_wr_ok", r_wr_ok, e.rok);
        cmp("R6", "both busy low", l_busy_n | r_busy_n, 1'b1);
      end
    end
  end

  initial begin
    // R1: reset state, with write requests present
    step(1, 1, 16'h0005, 1, 1, 16'h0005, 1, 1, 1, 1, 1, 0, 0, "R1");
    step(1, 0, 16'h0000, 0, 0, 16'h0000, 0, 1, 1, 1, 1, 0, 0, "R1");
    @(negedge clk); rst = 1'b0;
    step(1, 0, 16'h0000, 0, 0, 16'h0000, 0, 1, 1, 1, 1, 0, 0, "R1");
    // R2: different addresses, both writing
    step(1, 1, 16'h0005, 1, 1, 16'h0006, 1, 1, 1, 1, 1, 1, 1, "R2");
    // R4: right moves onto settled left address, right loses; R7 permits
    step(1, 1, 16'h0005, 1, 1, 16'h0005, 1, 1, 1, 1, 0, 1, 0, "R4");
    // R9 R3: right turns to read, lock holds
    step(1, 1, 16'h0005, 1, 1, 16'h0005, 0, 1, 1, 1, 0, 1, 0, "R9");
    step(1, 1, 16'h0005, 0, 1, 16'h0005, 1, 1, 1, 1, 0, 0, 0, "R3");
    // R8: left moves away
    step(1, 1, 16'h0007, 1, 1, 16'h0005, 1, 1, 1, 1, 1, 1, 1, "R8");
    // R2: both disabled on equal addresses
    step(1, 0, 16'h0009, 1, 0, 16'h0009, 1, 1, 1, 1, 1, 0, 0, "R2");
    // R5: both arrive in the same cycle
    step(1, 1, 16'h0009, 1, 1, 16'h0009, 1, 1, 1, 1, 0, 1, 0, "R5");
    // R8: right moves away
    step(1, 1, 16'h0009, 1, 1, 16'h0003, 0, 1, 1, 1, 1, 1, 0, "R8");
    // R4 R3: left moves onto settled right address, both reading
    step(1, 1, 16'h0003, 0, 1, 16'h0003, 0, 1, 1, 0, 1, 0, 0, "R4");
    // R9 R7: right writes, left tries to write, lock holds
    step(1, 1, 16'h0003, 1, 1, 16'h0003, 1, 1, 1, 0, 1, 0, 1, "R9");
    // R8: left enable drops while addresses still equal
    step(1, 0, 16'h0003, 1, 1, 16'h0003, 1, 1, 1, 1, 1, 0, 1, "R8");
    // R10: slave mode, matching addresses, busy inputs steer permits
    step(0, 1, 16'h0004, 1, 1, 16'h0004, 1, 1, 0, 1, 1, 1, 0, "R10");
    step(0, 1, 16'h0004, 1, 1, 16'h0004, 1, 0, 1, 1, 1, 0, 1, "R10");
    step(0, 1, 16'h0004, 1, 1, 16'h0004, 1, 1, 1, 1, 1, 1, 1, "R10");
    // back to master from a deselected state, tie again
    step(1, 0, 16'h0000, 0, 0, 16'h0000, 0, 1, 1, 1, 1, 0, 0, "R2");
    step(1, 1, 16'h00FF, 0, 1, 16'h00FF, 0, 1, 1, 1, 0, 0, 0, "R5");
    step(1, 0, 16'h00FF, 0, 0, 16'h00FF, 0, 1, 1, 1, 1, 0, 0, "R8");
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1 scoreboard leftover actual=%0d expected=0", q.size());
    end
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule